// File: doc/BRIEF.md
# Interrupt message vector controller

This block turns per-vector interrupt requests into message writes. It holds a table of `NVEC` entries. Each entry has a 64-bit message address, a 32-bit message data word and a 32-bit vector control word whose bit 0 masks that vector. Beside the table sit a read-only array of pending bits and a small control word with a global enable and a function mask. All of it is reached through a simple register port that takes 32-bit or 64-bit reads and writes.

When a request arrives on an enabled, unmasked vector, the block loads the entry's address and data into a valid/ready message output. Any request that cannot be sent at once sets that vector's pending bit. The held-back messages go out later without further requests. Clearing the function mask starts a sequential sweep over all vectors in ascending order. Clearing one vector's mask bit replays that vector alone if its pending bit is set.

Top module: `msix_ctrl`

## Requirements
- R1: After reset, every entry has address 0, data 0 and vector control 1 (masked). The control word reads `0x4000 | (NVEC-1)`, every pending bit is 0 and `msg_valid` is low.
- R2: Table space (`req_space`=0) gives each vector 16 bytes. The entry is the offset divided by 16. A 32-bit access at entry offset 0x0, 0x4, 0x8 or 0xC reaches address low, address high, data or vector control. Any other 32-bit offset, or an entry index of `NVEC` or more, reads 0 and ignores writes.
- R3: A 64-bit access at entry offset 0x0 covers {address high, address low}. A 64-bit access at offset 0x8 covers {vector control, data}, with vector control in bits 63:32. A 64-bit access at any other offset reads 0 and changes nothing.
- R4: The control word (`req_space`=2, offset ignored) holds `NVEC-1` in bits 10:0, the function mask in bit 14 and the enable in bit 15. A write changes only bits 14 and 15.
- R5: Pending space (`req_space`=1) packs the pending bit of vector v into bit v mod 64 of 64-bit word v/64. A 32-bit read at word offset 0x0 returns the low half and one at 0x4 the high half. A 64-bit read at offset 0x0 returns the whole word. Writes to this space are ignored.
- R6: A request on a vector whose mask bit is clear, while the block is enabled with the function mask clear and the output free, drives `msg_valid` high after the next edge. The output then carries that entry's address, data and vector index.
- R7: A request on a masked vector, or any request while the block is disabled or function-masked, sets the vector's pending bit and sends nothing.
- R8: While `msg_valid` is high and `msg_ready` low, the message outputs hold. Requests that arrive meanwhile set pending bits.
- R9: When a control write clears a set function mask, a sweep visits one vector per cycle in ascending order. Every unmasked vector with its pending bit set is sent and its pending bit cleared. The sweep stalls while the output is busy, and a register access during the sweep does not restart it.
- R10: A table write that clears a vector's mask bit while the block is enabled and not function-masked, with that vector pending, sends that vector's message and clears its pending bit.
- R11: A read request returns its data on `rsp_rdata` with `rsp_valid` high in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit |
| req_space | input | 2 | 0 table, 1 pending array, 2 control word, 3 unused |
| req_addr | input | ADDR_W | Byte offset within the space |
| req_wdata | input | 64 | Write data (32-bit writes use bits 31:0) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| irq_req | input | NVEC | Per-vector request pulses |
| msg_valid | output | 1 | Message pending on the output |
| msg_ready | input | 1 | Message accepted when high with `msg_valid` |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| msg_vec | output | VEC_W | Index of the vector being sent |

## Verification
A pending bit that is wrong inside the block shows up in the pending space read one cycle after the read request. The same error also shows as a message missing or extra once the mask is cleared. A sweep pointer that skips or repeats a vector shows in the order of the accepted messages, within NVEC cycles of the control write that clears the function mask. A wrong mask or table value shows as a message for a masked vector, or as a message carrying stale address or data, on the cycle after the request.

// File: rtl/msix_pkg.sv
package msix_pkg;

  typedef enum logic [1:0] {
    SP_TABLE = 2'd0,
    SP_PEND  = 2'd1,
    SP_CTRL  = 2'd2,
    SP_NONE  = 2'd3
  } space_e;

  localparam int CTL_FMASK_BIT  = 14;
  localparam int CTL_ENABLE_BIT = 15;

  // Index of the lowest set bit; zero when none is set.
  function automatic logic [5:0] low_idx(input logic [63:0] v);
    logic [5:0] r;
    r = '0;
    for (int i = 63; i >= 0; i--) begin
      if (v[i]) r = 6'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/msix_table.sv
module msix_table #(
  parameter int NVEC   = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wide,
  input  logic [ADDR_W-1:0] addr,
  input  logic [63:0]       wdata,
  output logic [63:0]       rd_val,
  output logic [NVEC-1:0]   vmask,
  output logic [NVEC-1:0]   unmask_hit,
  output logic [63:0]       ent_addr [NVEC],
  output logic [31:0]       ent_data [NVEC]
);
  localparam int IDX_W = ADDR_W - 4;

  logic [IDX_W-1:0] idx;
  logic [3:0]       off;
  logic [31:0]      lo_q [NVEC];
  logic [31:0]      hi_q [NVEC];
  logic [31:0]      da_q [NVEC];
  logic [31:0]      ct_q [NVEC];

  assign idx = addr[ADDR_W-1:4];
  assign off = addr[3:0];

  for (genvar v = 0; v < NVEC; v++) begin : g_ent
    logic        sel, w_lo, w_hi, w_da, w_ct;
    logic [31:0] ct_new;
    assign sel    = wr_en && (idx == IDX_W'(v));
    assign w_lo   = sel && (off == 4'h0);
    assign w_hi   = sel && ((wide && off == 4'h0) || (!wide && off == 4'h4));
    assign w_da   = sel && (off == 4'h8);
    assign w_ct   = sel && ((wide && off == 4'h8) || (!wide && off == 4'hC));
    assign ct_new = wide ? wdata[63:32] : wdata[31:0];

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q[v] <= '0;
        hi_q[v] <= '0;
        da_q[v] <= '0;
        ct_q[v] <= 32'h1;
      end else begin
        if (w_lo) lo_q[v] <= wdata[31:0];
        if (w_hi) hi_q[v] <= wide ? wdata[63:32] : wdata[31:0];
        if (w_da) da_q[v] <= wdata[31:0];
        if (w_ct) ct_q[v] <= ct_new;
      end
    end

    assign vmask[v]      = ct_q[v][0];
    assign unmask_hit[v] = w_ct && ct_q[v][0] && !ct_new[0];
    assign ent_addr[v]   = {hi_q[v], lo_q[v]};
    assign ent_data[v]   = da_q[v];
  end

  always_comb begin
    rd_val = '0;
    for (int v = 0; v < NVEC; v++) begin
      if (idx == IDX_W'(v)) begin
        if (wide) begin
          if (off == 4'h0)      rd_val = {hi_q[v], lo_q[v]};
          else if (off == 4'h8) rd_val = {ct_q[v], da_q[v]};
        end else begin
          case (off)
            4'h0:    rd_val = {32'h0, lo_q[v]};
            4'h4:    rd_val = {32'h0, hi_q[v]};
            4'h8:    rd_val = {32'h0, da_q[v]};
            4'hC:    rd_val = {32'h0, ct_q[v]};
            default: rd_val = '0;
          endcase
        end
      end
    end
  end

  // R3: a wide write at a misaligned offset leaves every mask untouched
  a_r3_bad_wide_keeps_mask: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wide && off != 4'h0 && off != 4'h8) |=> $stable(vmask));

endmodule

// File: rtl/msix_msg_out.sv
module msix_msg_out #(
  parameter int VEC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [63:0]      ld_addr,
  input  logic [31:0]      ld_data,
  input  logic [VEC_W-1:0] ld_vec,
  input  logic             msg_ready,
  output logic             free,
  output logic             msg_valid,
  output logic [63:0]      msg_addr,
  output logic [31:0]      msg_data,
  output logic [VEC_W-1:0] msg_vec
);
  assign free = !msg_valid || msg_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
      msg_vec   <= '0;
    end else if (ld) begin
      msg_valid <= 1'b1;
      msg_addr  <= ld_addr;
      msg_data  <= ld_data;
      msg_vec   <= ld_vec;
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  // R8: a message not yet accepted holds every field
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) &&
                                   $stable(msg_data) && $stable(msg_vec)));

  // R8: a new message is only loaded into a free output
  a_r8_no_overwrite: assert property (@(posedge clk) disable iff (rst)
    ld |-> free);

endmodule

// File: rtl/msix_ctrl.sv
module msix_ctrl #(
  parameter int NVEC   = 8,
  parameter int ADDR_W = 12,
  parameter int VEC_W  = (NVEC > 1) ? $clog2(NVEC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [1:0]        req_space,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  input  logic [NVEC-1:0]   irq_req,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [63:0]       msg_addr,
  output logic [31:0]       msg_data,
  output logic [VEC_W-1:0]  msg_vec
);
  import msix_pkg::*;

  localparam int NWORD = (NVEC + 63) / 64;
  localparam int PW_W  = ADDR_W - 3;

  logic              en_q, fm_q, scan_on;
  logic [VEC_W-1:0]  scan_idx;
  logic [NVEC-1:0]   pend_q, replay_q, vmask, unmask_hit;
  logic [63:0]       tbl_rd, ent_addr [NVEC];
  logic [31:0]       ent_data [NVEC];
  logic              tbl_wr, ctrl_wr, active, out_free;
  logic              scan_elig, scan_ld, rp_ld, irq_ld, ld;
  logic [VEC_W-1:0]  rp_vec, irq_vec, ld_vec;
  logic [NVEC-1:0]   irq_elig, rp_cand, clr, set_v;
  logic [NWORD*64-1:0] pend_ext;
  logic [63:0]       pw64, rd_mux;
  logic [15:0]       ctrl_word;

  assign tbl_wr  = req_valid && req_write && (req_space == SP_TABLE);
  assign ctrl_wr = req_valid && req_write && (req_space == SP_CTRL);
  assign active  = en_q && !fm_q;

  msix_table #(.NVEC(NVEC), .ADDR_W(ADDR_W)) u_table (
    .clk(clk), .rst(rst), .wr_en(tbl_wr), .wide(req_wide), .addr(req_addr),
    .wdata(req_wdata), .rd_val(tbl_rd), .vmask(vmask), .unmask_hit(unmask_hit),
    .ent_addr(ent_addr), .ent_data(ent_data));

  // Send arbitration: sweep first, then per-vector replay, then fresh requests.
  always_comb begin
    scan_elig = scan_on && !fm_q && !vmask[scan_idx] && pend_q[scan_idx];
    scan_ld   = scan_elig && out_free;
    rp_cand   = replay_q & ~vmask & pend_q & {NVEC{active}};
    rp_vec    = VEC_W'(low_idx(64'(rp_cand)));
    rp_ld     = (|rp_cand) && out_free && !scan_ld;
    irq_elig  = irq_req & ~vmask & {NVEC{active}};
    irq_vec   = VEC_W'(low_idx(64'(irq_elig)));
    irq_ld    = (|irq_elig) && out_free && !scan_ld && !rp_ld;
    ld        = scan_ld || rp_ld || irq_ld;
    ld_vec    = scan_ld ? scan_idx : (rp_ld ? rp_vec : irq_vec);
    clr       = (scan_ld ? (NVEC'(1) << scan_idx) : '0) |
                (rp_ld   ? (NVEC'(1) << rp_vec)   : '0);
    set_v     = irq_req & ~(irq_ld ? (NVEC'(1) << irq_vec) : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      fm_q     <= 1'b1;
      pend_q   <= '0;
      replay_q <= '0;
      scan_on  <= 1'b0;
      scan_idx <= '0;
    end else begin
      pend_q   <= (pend_q & ~clr) | set_v;
      replay_q <= (rp_cand & ~(rp_ld ? (NVEC'(1) << rp_vec) : '0)) |
                  (unmask_hit & pend_q & {NVEC{active}});
      if (ctrl_wr) begin
        en_q <= req_wdata[CTL_ENABLE_BIT];
        fm_q <= req_wdata[CTL_FMASK_BIT];
      end
      if (scan_on) begin
        if (!scan_elig || out_free) begin
          if (scan_idx == VEC_W'(NVEC - 1)) scan_on <= 1'b0;
          else scan_idx <= scan_idx + 1'b1;
        end
      end else if (ctrl_wr && fm_q && !req_wdata[CTL_FMASK_BIT]) begin
        scan_on  <= 1'b1;
        scan_idx <= '0;
      end
    end
  end

  msix_msg_out #(.VEC_W(VEC_W)) u_out (
    .clk(clk), .rst(rst), .ld(ld), .ld_addr(ent_addr[ld_vec]),
    .ld_data(ent_data[ld_vec]), .ld_vec(ld_vec), .msg_ready(msg_ready),
    .free(out_free), .msg_valid(msg_valid), .msg_addr(msg_addr),
    .msg_data(msg_data), .msg_vec(msg_vec));

  // Register read path
  assign ctrl_word = {en_q, fm_q, 3'b000, 11'(NVEC - 1)};

  always_comb begin
    pend_ext = '0;
    pend_ext[NVEC-1:0] = pend_q;
    pw64 = '0;
    for (int w = 0; w < NWORD; w++) begin
      if (req_addr[ADDR_W-1:3] == PW_W'(w)) pw64 = pend_ext[w*64 +: 64];
    end
    rd_mux = '0;
    case (req_space)
      SP_TABLE: rd_mux = tbl_rd;
      SP_PEND: begin
        if (req_wide) rd_mux = (req_addr[2:0] == 3'd0) ? pw64 : '0;
        else if (req_addr[2:0] == 3'd0) rd_mux = {32'h0, pw64[31:0]};
        else if (req_addr[2:0] == 3'd4) rd_mux = {32'h0, pw64[63:32]};
      end
      SP_CTRL: rd_mux = {48'h0, ctrl_word};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      rsp_rdata <= (req_valid && !req_write) ? rd_mux : '0;
    end
  end

  // R6: only unmasked vectors leave, and only with the function mask clear
  a_r6_unmasked_only: assert property (@(posedge clk) disable iff (rst)
    ld |-> (!vmask[ld_vec] && !fm_q));

  // R9: a sweep blocked by a busy output stays on the same vector
  a_r9_stall: assert property (@(posedge clk) disable iff (rst)
    (scan_on && scan_elig && !out_free) |=> (scan_on && $stable(scan_idx)));

  for (genvar v = 0; v < NVEC; v++) begin : g_chk
    // R7: a request that may not be sent leaves its pending bit set
    a_r7_pend_set: assert property (@(posedge clk) disable iff (rst)
      (irq_req[v] && (vmask[v] || !active)) |=> pend_q[v]);
  end

endmodule

// File: tb/tb_msix_ctrl.sv
module tb_msix_ctrl;
  localparam int NVEC = 8;
  localparam int ADDR_W = 12;
  localparam int VEC_W = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
  logic [1:0]        req_space = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [63:0]       req_wdata = '0;
  logic              rsp_valid;
  logic [63:0]       rsp_rdata;
  logic [NVEC-1:0]   irq_req = '0;
  logic              msg_valid;
  logic              msg_ready = 1'b1;
  logic [63:0]       msg_addr;
  logic [31:0]       msg_data;
  logic [VEC_W-1:0]  msg_vec;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_lo [NVEC], m_hi [NVEC], m_da [NVEC], m_ct [NVEC];
  int got_vec [64];
  int n_got = 0;

  always #5 clk = ~clk;

  msix_ctrl #(.NVEC(NVEC), .ADDR_W(ADDR_W)) dut (.*);

  always @(posedge clk) begin
    if (!rst && msg_valid && msg_ready && n_got < 64) begin
      got_vec[n_got] = int'(msg_vec);
      n_got++;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic bus_wr(input logic [1:0] sp, input logic wd, input int a, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_wide = wd; req_space = sp;
    req_addr = ADDR_W'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_rd(input logic [1:0] sp, input logic wd, input int a, output logic [63:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_wide = wd; req_space = sp; req_addr = ADDR_W'(a);
    @(negedge clk);
    req_valid = 0;
    d = rsp_rdata;
  endtask

  task automatic pulse(input logic [NVEC-1:0] m);
    @(negedge clk);
    irq_req = m;
    @(negedge clk);
    irq_req = '0;
  endtask

  task automatic mdl_wr(input logic wd, input int a, input logic [63:0] d);
    int idx = a / 16;
    int off = a % 16;
    if (idx >= NVEC) return;
    if (wd) begin
      if (off == 0) begin m_lo[idx] = d[31:0]; m_hi[idx] = d[63:32]; end
      else if (off == 8) begin m_da[idx] = d[31:0]; m_ct[idx] = d[63:32]; end
    end else begin
      case (off)
        0: m_lo[idx] = d[31:0];
        4: m_hi[idx] = d[31:0];
        8: m_da[idx] = d[31:0];
        12: m_ct[idx] = d[31:0];
        default: ;
      endcase
    end
  endtask

  function automatic logic [63:0] mdl_rd(input logic wd, input int a);
    int idx = a / 16;
    int off = a % 16;
    if (idx >= NVEC) return '0;
    if (wd) begin
      if (off == 0) return {m_hi[idx], m_lo[idx]};
      if (off == 8) return {m_ct[idx], m_da[idx]};
      return '0;
    end
    case (off)
      0: return {32'h0, m_lo[idx]};
      4: return {32'h0, m_hi[idx]};
      8: return {32'h0, m_da[idx]};
      12: return {32'h0, m_ct[idx]};
      default: return '0;
    endcase
  endfunction

  function automatic logic [63:0] exp_addr(input int v);
    return {32'hC0DE_0000 | 32'(v), 32'hFEE0_0000 + 32'(v * 16)};
  endfunction

  function automatic logic [31:0] exp_data(input int v);
    return 32'h4100 + 32'(v);
  endfunction

  task automatic tbl_set(input int a, input logic wd, input logic [63:0] d);
    bus_wr(2'd0, wd, a, d);
    mdl_wr(wd, a, d);
  endtask

  initial begin
    logic [63:0] rd;
    int a, base;
    void'($urandom(32'h5EED));
    for (int v = 0; v < NVEC; v++) begin
      m_lo[v] = 0; m_hi[v] = 0; m_da[v] = 0; m_ct[v] = 1;
    end
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    chk("R1 msg_valid", 64'(msg_valid), 64'h0);
    bus_rd(2'd2, 0, 0, rd); chk("R1 ctrl", rd, 64'h4007);
    chk("R11 rsp_valid", 64'(rsp_valid), 64'h1);
    bus_rd(2'd1, 1, 0, rd); chk("R1 pending", rd, 64'h0);
    bus_rd(2'd0, 0, 2*16+12, rd); chk("R1 vctl", rd, 64'h1);
    bus_rd(2'd0, 1, 5*16, rd); chk("R1 addr", rd, 64'h0);

    // R2/R3 random table accesses against the model (block disabled, masked)
    for (int i = 0; i < 80; i++) begin
      logic wd;
      logic [63:0] d;
      int r = int'($urandom % 4);
      base = int'($urandom % 11) * 16;
      a = base + ((r == 0) ? int'($urandom % 16) : r * 4 - 4 + int'($urandom % 2) * 4);
      wd = 1'($urandom);
      d = {$urandom, $urandom};
      tbl_set(a, wd, d);
      wd = 1'($urandom);
      a = int'($urandom % 11) * 16 + ((($urandom % 4) == 0) ? int'($urandom % 16) : int'($urandom % 4) * 4);
      bus_rd(2'd0, wd, a, rd);
      chk(wd ? "R3 wide table read" : "R2 narrow table read", rd, mdl_rd(wd, a));
    end
    // R3 directed: misaligned wide write ignored
    tbl_set(3*16, 1, 64'h1111_2222_3333_4444);
    tbl_set(3*16+4, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    bus_rd(2'd0, 1, 3*16, rd); chk("R3 misaligned wide write ignored", rd, 64'h1111_2222_3333_4444);
    bus_rd(2'd0, 1, 3*16+12, rd); chk("R3 misaligned wide read", rd, 64'h0);

    // R4 control word
    bus_wr(2'd2, 0, 0, 64'hFFFF_FFFF);
    bus_rd(2'd2, 0, 0, rd); chk("R4 ctrl all ones", rd, 64'hC007);
    bus_wr(2'd2, 0, 0, 64'h4000);
    bus_rd(2'd2, 0, 0, rd); chk("R4 ctrl mask only", rd, 64'h4007);

    // Known table: every vector masked, then 1,3,5 unmasked
    for (int v = 0; v < NVEC; v++) begin
      tbl_set(v*16, 1, exp_addr(v));
      tbl_set(v*16+8, 1, {32'h1, exp_data(v)});
    end
    tbl_set(1*16+12, 0, 64'h0);
    tbl_set(3*16+12, 0, 64'h0);
    tbl_set(5*16+12, 0, 64'h0);

    // R7 disabled and function-masked: requests pend
    pulse(8'h6A);
    repeat (2) @(negedge clk);
    chk("R7 no message while blocked", 64'(msg_valid), 64'h0);
    chk("R7 nothing accepted", 64'(n_got), 64'h0);

    // R5 pending layout and read-only
    bus_rd(2'd1, 0, 0, rd); chk("R5 pending low half", rd, 64'h6A);
    bus_rd(2'd1, 0, 4, rd); chk("R5 pending high half", rd, 64'h0);
    bus_wr(2'd1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    bus_rd(2'd1, 1, 0, rd); chk("R5 pending write ignored", rd, 64'h6A);
    bus_rd(2'd1, 1, 4, rd); chk("R5 wide misaligned", rd, 64'h0);

    // R9 sweep on function-mask clear with a stalled output
    bus_wr(2'd2, 0, 0, 64'hC000);
    @(negedge clk); msg_ready = 0;
    bus_wr(2'd2, 0, 0, 64'h8000);
    repeat (8) @(negedge clk);
    chk("R9 first swept vector", 64'(msg_vec), 64'd1);
    chk("R9 valid while stalled", 64'(msg_valid), 64'h1);
    chk("R9 swept address", msg_addr, exp_addr(1));
    chk("R9 swept data", 64'(msg_data), 64'(exp_data(1)));
    bus_rd(2'd1, 0, 0, rd); chk("R9 stall keeps later pending", rd, 64'h68);
    repeat (3) @(negedge clk);
    chk("R8 hold vector", 64'(msg_vec), 64'd1);
    chk("R8 hold address", msg_addr, exp_addr(1));
    msg_ready = 1;
    repeat (20) @(negedge clk);
    chk("R9 sweep count", 64'(n_got), 64'd3);
    chk("R9 order 0", 64'(got_vec[0]), 64'd1);
    chk("R9 order 1", 64'(got_vec[1]), 64'd3);
    chk("R9 order 2", 64'(got_vec[2]), 64'd5);
    bus_rd(2'd1, 0, 0, rd); chk("R9 pending after sweep", rd, 64'h40);

    // R6 direct send
    pulse(8'h08);
    chk("R6 valid", 64'(msg_valid), 64'h1);
    chk("R6 vector", 64'(msg_vec), 64'd3);
    chk("R6 address", msg_addr, exp_addr(3));
    chk("R6 data", 64'(msg_data), 64'(exp_data(3)));
    repeat (2) @(negedge clk);

    // R7 masked vector while active
    pulse(8'h80);
    repeat (2) @(negedge clk);
    chk("R7 masked count", 64'(n_got), 64'd4);
    bus_rd(2'd1, 0, 0, rd); chk("R7 masked pends", rd, 64'hC0);

    // R10 per-vector unmask replays pending vector 6
    tbl_set(6*16+12, 0, 64'h0);
    repeat (4) @(negedge clk);
    chk("R10 replay count", 64'(n_got), 64'd5);
    chk("R10 replay vector", 64'(got_vec[4]), 64'd6);
    bus_rd(2'd1, 0, 0, rd); chk("R10 pending cleared", rd, 64'h80);

    // R8 requests while busy pend
    @(negedge clk); msg_ready = 0;
    pulse(8'h02);
    pulse(8'h08);
    chk("R8 busy vector", 64'(msg_vec), 64'd1);
    bus_rd(2'd1, 0, 0, rd); chk("R8 busy request pends", rd, 64'h88);
    msg_ready = 1;
    repeat (3) @(negedge clk);
    chk("R8 accepted", 64'(n_got), 64'd6);

    summary();
    $finish;
  end
endmodule